// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps wall-clock time and date as packed BCD registers: seconds, minutes, hours (24-hour), day of month, weekday, month and a two-digit year. A one-pulse-per-second enable drives it. On a single tick every rollover ripples through the chain, from seconds up to the year. The day-of-month limit follows the current month and a leap-year rule applied to the BCD year.

Software sets the time through a parallel load port. A per-register enable picks which of the seven registers take their byte, and each loaded byte is trimmed to the width of its field. A stop input freezes counting so that a multi-register update can be made without a tick tearing it.

The top bit of the seconds output is a sticky flag meaning "time not trustworthy". Reset and a power-fail indication set it. Only a seconds load with that bit at zero clears it.

Top module: `bcd_calendar`

## Requirements
- R1: After reset the outputs are seconds 0x80 (flag set, 00 seconds), minutes 0x00, hours 0x00, day 0x01, weekday 0x00, month 0x01, year 0x00, and `osc_stop_o` is 1.
- R2: Each cycle with `tick_i` high, `stop_i` low and no load, seconds advance by one in BCD (0x09 to 0x10) on the next clock edge. Seconds 0x59 wrap to 0x00 and carry into minutes.
- R3: Minutes wrap from 0x59 to 0x00 and carry into hours. Hours wrap from 0x23 to 0x00 and carry into the day.
- R4: Every day carry advances the weekday (bits 2:0) by one, and weekday 6 wraps to 0.
- R5: The day of month wraps to 0x01 after 0x30 in months 0x04, 0x06, 0x09 and 0x11, and after 0x31 in the other months except February. The wrap carries into the month.
- R6: February ends after 0x29 when the BCD year is divisible by four (00 counts as leap), and after 0x28 otherwise.
- R7: Month 0x12 wraps to 0x01 and carries into the year. Year 0x99 wraps to 0x00. A tick at 99-12-31 23:59:59 gives 00-01-01 00:00:00 one cycle later.
- R8: While `stop_i` is high, ticks are ignored and all time fields hold. Loads still apply. Counting resumes when `stop_i` falls.
- R9: `ld_en_i` bit k loads byte k of `ld_val_i` (bits 8k+7:8k). The order is 0 seconds, 1 minutes, 2 hours, 3 day, 4 weekday, 5 month, 6 year. Each byte is masked to its field width: 7, 7, 6, 6, 3, 5 and 8 bits. A cycle with any load bit set ignores `tick_i` entirely.
- R10: `osc_stop_o` equals bit 7 of `sec_o`. `pwr_fail_i` sets it. It then stays set until a seconds load with bit 7 at 0. A seconds load with bit 7 at 1 leaves it unchanged. `pwr_fail_i` wins over a clearing load in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick_i | input | 1 | One-cycle enable per elapsed second |
| stop_i | input | 1 | Freezes counting while high |
| pwr_fail_i | input | 1 | Power-on or oscillator-loss indication; sets the invalid flag |
| ld_en_i | input | 7 | Per-register load enables |
| ld_val_i | input | 56 | Load bytes, byte k for register k |
| sec_o | output | 8 | Invalid flag in bit 7, BCD seconds in bits 6:0 |
| min_o | output | 8 | BCD minutes |
| hour_o | output | 8 | BCD hours, 00 to 23 |
| mday_o | output | 8 | BCD day of month |
| wday_o | output | 8 | Weekday 0 to 6 |
| mon_o | output | 8 | BCD month, 01 to 12 |
| year_o | output | 8 | BCD year, 00 to 99 |
| osc_stop_o | output | 1 | Time-invalid flag |

## Verification
The hard states to reach from the ports are the month ends, the leap days and the end-of-century rollover. Reaching them by ticking would take months to a century of simulated seconds. The stimulus uses the parallel load to place the counters one or two ticks before each boundary: 30- and 31-day months, February in leap years such as 00, 12 and 96, February in a non-leap year such as 10, and 99-12-31 23:59:59. It then ticks across the boundary while a behavioural calendar model is compared every cycle.

// File: rtl/cal_pkg.sv
package cal_pkg;

  localparam int NREG = 7;

  localparam int IDX_SEC  = 0;
  localparam int IDX_MIN  = 1;
  localparam int IDX_HOUR = 2;
  localparam int IDX_MDAY = 3;
  localparam int IDX_WDAY = 4;
  localparam int IDX_MON  = 5;
  localparam int IDX_YEAR = 6;

  // storage bits kept per field
  localparam int FIELD_W [NREG] = '{7, 7, 6, 6, 3, 5, 8};
  // last value before a wrap (day of month is overridden at run time)
  localparam logic [7:0] FIELD_MAX [NREG] =
    '{8'h59, 8'h59, 8'h23, 8'h31, 8'h06, 8'h12, 8'h99};
  // value restarted from after a wrap, also the reset value
  localparam logic [7:0] FIELD_LOW [NREG] =
    '{8'h00, 8'h00, 8'h00, 8'h01, 8'h00, 8'h01, 8'h00};

  localparam logic [4:0] MON_FEB = 5'h02;

  // two-digit BCD increment, no range check
  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    logic [7:0] r;
    if (v[3:0] >= 4'd9) r = {v[7:4] + 4'd1, 4'h0};
    else                r = {v[7:4], v[3:0] + 4'd1};
    return r;
  endfunction

  // divisible by four: even tens with units 0/4/8, odd tens with units 2/6
  function automatic logic leap_bcd(input logic [7:0] y);
    logic r;
    if (y[4]) r = (y[3:0] == 4'd2) || (y[3:0] == 4'd6);
    else      r = (y[3:0] == 4'd0) || (y[3:0] == 4'd4) || (y[3:0] == 4'd8);
    return r;
  endfunction

endpackage

// File: rtl/cal_bcd_cnt.sv
module cal_bcd_cnt
  import cal_pkg::*;
#(
  parameter int         W   = 7,
  parameter logic [7:0] LOW = 8'h00
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         inc_i,
  input  logic [7:0]   lim_i,
  output logic [W-1:0] val_o,
  output logic         wrap_o
);

  logic [W-1:0] q_r;
  logic [W-1:0] q_nx;
  logic [7:0]   q8;
  logic         at_lim;
  logic         en;

  assign q8     = 8'(q_r);
  assign at_lim = (q8 >= lim_i);
  assign wrap_o = inc_i & ~ld_i & at_lim;
  assign en     = ld_i | inc_i;

  always_comb begin
    q_nx = q_r;
    if (ld_i) begin
      q_nx = ld_val_i;
    end else if (inc_i) begin
      if (at_lim) q_nx = W'(LOW);
      else        q_nx = W'(bcd_inc(q8));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= W'(LOW);
    else if (en) q_r <= q_nx;
  end

  assign val_o = q_r;

  AST_WRAP_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    wrap_o |=> (q_r == W'(LOW))) else $error("carry without restart"); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_i && !inc_i) |=> $stable(q_r)) else $error("field moved without cause"); // R8

endmodule

// File: rtl/cal_wday.sv
module cal_wday #(
  parameter int DAYS = 7,
  parameter int W    = $clog2(DAYS)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld_i,
  input  logic [W-1:0] ld_val_i,
  input  logic         inc_i,
  output logic [W-1:0] val_o
);

  localparam logic [W-1:0] LAST = W'(DAYS - 1);

  logic [W-1:0] q_r;
  logic [W-1:0] q_nx;
  logic         en;

  assign en = ld_i | inc_i;

  always_comb begin
    q_nx = q_r;
    if (ld_i)                q_nx = ld_val_i;
    else if (q_r >= LAST)    q_nx = '0;
    else                     q_nx = q_r + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q_r <= '0;
    else if (en) q_r <= q_nx;
  end

  assign val_o = q_r;

  AST_WDAY_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !ld_i && q_r == LAST) |=> (q_r == '0)) else $error("weekday wrap"); // R4

endmodule

// File: rtl/cal_month_len.sv
module cal_month_len
  import cal_pkg::*;
(
  input  logic [4:0] mon_i,
  input  logic [7:0] year_i,
  output logic [7:0] last_o
);

  always_comb begin
    case (mon_i)
      MON_FEB:                    last_o = leap_bcd(year_i) ? 8'h29 : 8'h28;
      5'h04, 5'h06, 5'h09, 5'h11: last_o = 8'h30;
      default:                    last_o = 8'h31;
    endcase
  end

endmodule

// File: rtl/bcd_calendar.sv
module bcd_calendar
  import cal_pkg::*;
#(
  parameter int DAYS_PER_WEEK = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              stop_i,
  input  logic              pwr_fail_i,
  input  logic [NREG-1:0]   ld_en_i,
  input  logic [8*NREG-1:0] ld_val_i,
  output logic [7:0]        sec_o,
  output logic [7:0]        min_o,
  output logic [7:0]        hour_o,
  output logic [7:0]        mday_o,
  output logic [7:0]        wday_o,
  output logic [7:0]        mon_o,
  output logic [7:0]        year_o,
  output logic              osc_stop_o
);

  // reset synchronizer: asserts at once, releases on the clock
  logic [1:0] rst_sync_r;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_r <= 2'b00;
    else        rst_sync_r <= {rst_sync_r[0], 1'b1};
  end
  assign rst_n_s = rst_sync_r[1];

  logic            adv;
  logic [NREG-1:0] inc;
  logic [NREG-1:0] wrap;
  logic [7:0]      fld [NREG];
  logic [7:0]      mday_last;

  // a load anywhere drops the tick for the whole cycle
  assign adv = tick_i & ~stop_i & ~(|ld_en_i);

  // carry chain: sec -> min -> hour -> (mday, wday) -> mon -> year
  assign inc[IDX_SEC]  = adv;
  assign inc[IDX_MIN]  = wrap[IDX_SEC];
  assign inc[IDX_HOUR] = wrap[IDX_MIN];
  assign inc[IDX_MDAY] = wrap[IDX_HOUR];
  assign inc[IDX_WDAY] = wrap[IDX_HOUR];
  assign inc[IDX_MON]  = wrap[IDX_MDAY];
  assign inc[IDX_YEAR] = wrap[IDX_MON];

  cal_month_len u_mlen (
    .mon_i  (fld[IDX_MON][4:0]),
    .year_i (fld[IDX_YEAR]),
    .last_o (mday_last)
  );

  for (genvar g = 0; g < NREG; g++) begin : g_fld
    if (g == IDX_WDAY) begin : g_wd
      logic [FIELD_W[g]-1:0] v;
      cal_wday #(.DAYS(DAYS_PER_WEEK), .W(FIELD_W[g])) u_wday (
        .clk      (clk),
        .rst_n    (rst_n_s),
        .ld_i     (ld_en_i[g]),
        .ld_val_i (ld_val_i[8*g +: FIELD_W[g]]),
        .inc_i    (inc[g]),
        .val_o    (v)
      );
      assign fld[g]  = 8'(v);
      assign wrap[g] = 1'b0;
    end else begin : g_bcd
      logic [FIELD_W[g]-1:0] v;
      cal_bcd_cnt #(.W(FIELD_W[g]), .LOW(FIELD_LOW[g])) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n_s),
        .ld_i     (ld_en_i[g]),
        .ld_val_i (ld_val_i[8*g +: FIELD_W[g]]),
        .inc_i    (inc[g]),
        .lim_i    ((g == IDX_MDAY) ? mday_last : FIELD_MAX[g]),
        .val_o    (v),
        .wrap_o   (wrap[g])
      );
      assign fld[g] = 8'(v);
    end
  end

  // sticky time-invalid flag
  logic flag_r;
  logic flag_nx;
  logic flag_en;

  assign flag_en = pwr_fail_i | ld_en_i[IDX_SEC];

  always_comb begin
    flag_nx = flag_r;
    if (pwr_fail_i)                                    flag_nx = 1'b1;
    else if (ld_en_i[IDX_SEC] && !ld_val_i[8*IDX_SEC+7]) flag_nx = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s)     flag_r <= 1'b1;
    else if (flag_en) flag_r <= flag_nx;
  end

  assign sec_o      = {flag_r, fld[IDX_SEC][6:0]};
  assign min_o      = fld[IDX_MIN];
  assign hour_o     = fld[IDX_HOUR];
  assign mday_o     = fld[IDX_MDAY];
  assign wday_o     = fld[IDX_WDAY];
  assign mon_o      = fld[IDX_MON];
  assign year_o     = fld[IDX_YEAR];
  assign osc_stop_o = flag_r;

  logic unused_bits;
  assign unused_bits = ^{ld_val_i[15], ld_val_i[23:22], ld_val_i[31:30],
                         ld_val_i[39:35], ld_val_i[47:45],
                         wrap[IDX_WDAY], wrap[IDX_YEAR]};

  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (stop_i && ld_en_i == '0) |=>
      ($stable(sec_o[6:0]) && $stable({min_o, hour_o, mday_o, wday_o, mon_o, year_o})))
    else $error("time moved while stopped"); // R8

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n_s)
    ld_en_i[IDX_MIN] |=> (min_o == {1'b0, $past(ld_val_i[14:8])}))
    else $error("minute load lost"); // R9

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n_s)
    pwr_fail_i |=> osc_stop_o) else $error("flag not set"); // R10

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n_s)
    (osc_stop_o && !ld_en_i[IDX_SEC]) |=> osc_stop_o) else $error("flag dropped"); // R10

  AST_FULL_RIPPLE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (adv && sec_o[6:0] == 7'h59 && min_o == 8'h59 && hour_o == 8'h23 &&
     mday_o == mday_last && mon_o == 8'h12 && year_o == 8'h99) |=>
      (sec_o[6:0] == 7'h00 && min_o == 8'h00 && hour_o == 8'h00 &&
       mday_o == 8'h01 && mon_o == 8'h01 && year_o == 8'h00))
    else $error("century rollover"); // R7

endmodule

// File: tb/bcd_calendar_tb.sv
module bcd_calendar_tb;

  localparam int CLK_P = 10;

  logic        clk;
  logic        rst_n;
  logic        tick;
  logic        stop;
  logic        pfail;
  logic [6:0]  ld_en;
  logic [55:0] ld_val;
  logic [7:0]  sec_o, min_o, hour_o, mday_o, wday_o, mon_o, year_o;
  logic        osc_stop_o;

  int    errors = 0;
  int    checks = 0;
  string cur_req = "R1";
  bit    cmp_on = 0;

  bcd_calendar u_dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .stop_i(stop), .pwr_fail_i(pfail),
    .ld_en_i(ld_en), .ld_val_i(ld_val),
    .sec_o(sec_o), .min_o(min_o), .hour_o(hour_o), .mday_o(mday_o),
    .wday_o(wday_o), .mon_o(mon_o), .year_o(year_o), .osc_stop_o(osc_stop_o)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  // ---------------- behavioural calendar model ----------------
  int m_s, m_mi, m_h, m_d, m_wd, m_mo, m_y;
  bit m_f;

  function automatic int b2i(input logic [7:0] x);
    return int'(x[7:4]) * 10 + int'(x[3:0]);
  endfunction

  function automatic logic [7:0] i2b(input int v);
    return 8'(((v / 10) * 16) + (v % 10));
  endfunction

  function automatic int days_in(input int mo, input int y);
    if (mo == 2) return (y % 4 == 0) ? 29 : 28;
    if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
    return 31;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_s = 0; m_mi = 0; m_h = 0; m_d = 1; m_wd = 0; m_mo = 1; m_y = 0; m_f = 1;
    end else begin
      if (pfail) m_f = 1;
      else if (ld_en[0] && !ld_val[7]) m_f = 0;
      if (ld_en != 0) begin
        if (ld_en[0]) m_s  = b2i({1'b0, ld_val[6:0]});
        if (ld_en[1]) m_mi = b2i({1'b0, ld_val[14:8]});
        if (ld_en[2]) m_h  = b2i({2'b0, ld_val[21:16]});
        if (ld_en[3]) m_d  = b2i({2'b0, ld_val[29:24]});
        if (ld_en[4]) m_wd = int'(ld_val[34:32]);
        if (ld_en[5]) m_mo = b2i({3'b0, ld_val[44:40]});
        if (ld_en[6]) m_y  = b2i(ld_val[55:48]);
      end else if (tick && !stop) begin
        m_s++;
        if (m_s == 60) begin
          m_s = 0; m_mi++;
          if (m_mi == 60) begin
            m_mi = 0; m_h++;
            if (m_h == 24) begin
              m_h = 0;
              m_wd = (m_wd >= 6) ? 0 : m_wd + 1;
              m_d++;
              if (m_d > days_in(m_mo, m_y)) begin
                m_d = 1; m_mo++;
                if (m_mo > 12) begin
                  m_mo = 1; m_y = (m_y + 1) % 100;
                end
              end
            end
          end
        end
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (cmp_on) begin
      logic [56:0] act, exp;
      act = {sec_o, min_o, hour_o, mday_o, wday_o, mon_o, year_o, osc_stop_o};
      exp = {i2b(m_s) | (m_f ? 8'h80 : 8'h00), i2b(m_mi), i2b(m_h), i2b(m_d),
             8'(m_wd), i2b(m_mo), i2b(m_y), m_f};
      checks++;
      if (act !== exp) begin
        errors++;
        $display("FAIL %s model compare: actual=%h expected=%h", cur_req, act, exp);
      end
    end
  end

  // ---------------- tasks ----------------
  task automatic chk(input string req, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic step(input logic tk, input logic stp, input logic pf,
                      input logic [6:0] en, input logic [55:0] val);
    tick = tk; stop = stp; pfail = pf; ld_en = en; ld_val = val;
    @(negedge clk);
    tick = 1'b0; stop = 1'b0; pfail = 1'b0; ld_en = '0; ld_val = '0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) step(1'b1, 1'b0, 1'b0, 7'h00, 56'h0);
  endtask

  task automatic set_time(input logic [7:0] y, input logic [7:0] mo,
                          input logic [7:0] d, input logic [7:0] wd,
                          input logic [7:0] h, input logic [7:0] mi,
                          input logic [7:0] s);
    step(1'b0, 1'b0, 1'b0, 7'h7F, {y, mo, wd, d, h, mi, s});
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finished");
    finish_run();
  end

  // ---------------- stimulus ----------------
  initial begin
    rst_n = 1'b0; tick = 1'b0; stop = 1'b0; pfail = 1'b0; ld_en = '0; ld_val = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    chk("R1", "sec",  sec_o,  8'h80);
    chk("R1", "min",  min_o,  8'h00);
    chk("R1", "hour", hour_o, 8'h00);
    chk("R1", "mday", mday_o, 8'h01);
    chk("R1", "wday", wday_o, 8'h00);
    chk("R1", "mon",  mon_o,  8'h01);
    chk("R1", "year", year_o, 8'h00);
    chk("R1", "flag", {7'b0, osc_stop_o}, 8'h01);
    cmp_on = 1;

    // R10 flag behaviour
    cur_req = "R10";
    ticks(3);
    chk("R10", "flag kept while counting", sec_o, 8'h83);
    step(0, 0, 0, 7'h01, 56'h90);
    chk("R10", "load with bit7=1 keeps flag", sec_o, 8'h90);
    step(0, 0, 0, 7'h01, 56'h05);
    chk("R10", "load with bit7=0 clears flag", sec_o, 8'h05);
    step(0, 0, 0, 7'h01, 56'h87);
    chk("R10", "load with bit7=1 does not set", sec_o, 8'h07);
    step(0, 0, 1, 7'h00, 56'h0);
    chk("R10", "power fail sets flag", {7'b0, osc_stop_o}, 8'h01);
    step(0, 0, 0, 7'h01, 56'h11);
    step(0, 0, 1, 7'h01, 56'h22);
    chk("R10", "power fail beats clearing load", sec_o, 8'hA2);

    // R2 seconds counting and minute carry
    cur_req = "R2";
    set_time(8'h23, 8'h06, 8'h15, 8'h03, 8'h10, 8'h20, 8'h05);
    chk("R9", "all-field load clears flag", sec_o, 8'h05);
    ticks(4);
    chk("R2", "sec 09", sec_o, 8'h09);
    ticks(1);
    chk("R2", "BCD step 09->10", sec_o, 8'h10);
    ticks(55);
    chk("R2", "minute carry", min_o, 8'h21);
    chk("R2", "sec after wrap", sec_o, 8'h05);

    // R3 R4 R5 day end in a 30-day month
    cur_req = "R3";
    set_time(8'h23, 8'h04, 8'h30, 8'h06, 8'h23, 8'h59, 8'h58);
    ticks(2);
    chk("R3", "hour wrap", hour_o, 8'h00);
    chk("R3", "minute wrap", min_o, 8'h00);
    chk("R4", "weekday 6->0", wday_o, 8'h00);
    chk("R5", "Apr 30 -> day 01", mday_o, 8'h01);
    chk("R5", "Apr 30 -> May", mon_o, 8'h05);

    cur_req = "R5";
    set_time(8'h23, 8'h01, 8'h31, 8'h01, 8'h23, 8'h59, 8'h59);
    ticks(1);
    chk("R5", "Jan 31 -> Feb", mon_o, 8'h02);
    chk("R4", "weekday 1->2", wday_o, 8'h02);
    set_time(8'h23, 8'h01, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59);
    ticks(1);
    chk("R5", "Jan 30 -> 31", mday_o, 8'h31);
    set_time(8'h23, 8'h11, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59);
    ticks(1);
    chk("R5", "Nov 30 -> Dec", mon_o, 8'h12);
    set_time(8'h23, 8'h09, 8'h30, 8'h01, 8'h23, 8'h59, 8'h59);
    ticks(1);
    chk("R5", "Sep 30 -> Oct", mon_o, 8'h10);

    // R6 February
    cur_req = "R6";
    set_time(8'h23, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    ticks(1);
    chk("R6", "Feb 28 year 23 -> Mar", mon_o, 8'h03);
    set_time(8'h24, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    ticks(1);
    chk("R6", "Feb 28 year 24 -> 29", mday_o, 8'h29);
    step(0, 0, 0, 7'h07, {32'h0, 8'h23, 8'h59, 8'h59});
    ticks(1);
    chk("R6", "Feb 29 year 24 -> Mar", mon_o, 8'h03);
    set_time(8'h00, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    ticks(1);
    chk("R6", "year 00 leap", mday_o, 8'h29);
    set_time(8'h96, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    ticks(1);
    chk("R6", "year 96 leap", mday_o, 8'h29);
    set_time(8'h12, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    ticks(1);
    chk("R6", "year 12 leap", mday_o, 8'h29);
    set_time(8'h10, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
    ticks(1);
    chk("R6", "year 10 not leap", mon_o, 8'h03);

    // R7 full ripple
    cur_req = "R7";
    set_time(8'h99, 8'h12, 8'h31, 8'h02, 8'h23, 8'h59, 8'h59);
    ticks(1);
    chk("R7", "year wrap", year_o, 8'h00);
    chk("R7", "month wrap", mon_o, 8'h01);
    chk("R7", "day wrap", mday_o, 8'h01);
    chk("R7", "sec wrap", sec_o, 8'h00);
    chk("R7", "weekday", wday_o, 8'h03);

    // R8 stop
    cur_req = "R8";
    ticks(3);
    for (int i = 0; i < 10; i++) step(1, 1, 0, 7'h00, 56'h0);
    chk("R8", "sec frozen", sec_o, 8'h03);
    step(0, 1, 0, 7'h02, {40'h0, 8'h45, 8'h00});
    chk("R8", "load during stop", min_o, 8'h45);
    ticks(1);
    chk("R8", "resume", sec_o, 8'h04);

    // R9 load priority and masking
    cur_req = "R9";
    step(1, 0, 0, 7'h01, 56'h30);
    chk("R9", "load beats tick", sec_o, 8'h30);
    step(1, 0, 0, 7'h02, {40'h0, 8'h10, 8'h00});
    chk("R9", "other-field load drops tick", sec_o, 8'h30);
    chk("R9", "minute loaded", min_o, 8'h10);
    step(0, 0, 0, 7'h7E, {8'h42, 8'hF2, 8'hFD, 8'hC7, 8'hD3, 8'h85, 8'h00});
    chk("R9", "min mask", min_o, 8'h05);
    chk("R9", "hour mask", hour_o, 8'h13);
    chk("R9", "mday mask", mday_o, 8'h07);
    chk("R9", "wday mask", wday_o, 8'h05);
    chk("R9", "mon mask", mon_o, 8'h12);
    chk("R9", "year", year_o, 8'h42);
    ticks(2);

    finish_run();
  end

endmodule